// File: doc/BRIEF.md
# Descriptor Ring Command Queue Engine

This block is the per-port queue engine of a storage host controller. Software places 32-byte command descriptors in a ring of 32 slots in system memory. It then moves the request in-pointer forward through a small register file. Whenever the request in-pointer index differs from the engine's request out-pointer index, the engine reads the eight descriptor words of the next slot over a valid/ready memory-read port. It latches all eight words and presents the whole descriptor on a command output. It then holds the descriptor until the transport side pulses a done strobe with a status word.

After completion the engine writes one 8-byte response entry into a response ring. The entry holds the slot index and the returned status. The engine then advances both its request out-pointer and its response in-pointer, and sets this port's bit in a cause register that software clears. Each ring pointer register holds the ring base above a 5-bit index field. Software stops the engine with a disable bit that clears itself. The enable bit keeps reading 1 until the command in flight has finished. A channel-reset bit puts the pointers and the sequencer back to their start state, and a freeze bit holds off new work.

Top module: `dq_ring_engine`

## Requirements
- R1: After reset every register reads 0, and `cmd_valid`, `rd_req_valid` and `rsp_wr_valid` are low.
- R2: Register offsets are: command 0, request in-pointer 1, request out-pointer 2, response in-pointer 3, response out-pointer 4, cause 5. The request pointers carry their slot index in bits [9:5] and the response pointers carry it in bits [7:3]. Bits below the index always read 0. While the engine is disabled, a write to any pointer stores the whole value, with those low bits forced to 0.
- R3: While enabled, the engine starts a command when index(request-in) differs from index(request-out). For each word k from 0 to 7 it issues one read at address {request-in[31:10], request-out index, 5'b0} + 4k and waits for the returned beat. It raises `cmd_valid` only after all eight words are latched, with word k in `cmd_desc[32k+31:32k]`. `cmd_valid` and `cmd_desc` then hold steady until `cmd_done`.
- R4: After `cmd_done`, the engine makes one 64-bit write at {response-out[31:8], response-in index, 3'b0}. Its data is {status, 27'b0, request slot index}. When that write is accepted, the request out-pointer index and the response in-pointer index each advance by one.
- R5: All ring indices wrap from 31 to 0.
- R6: Each accepted response write sets cause bit PORT_ID (bit 0 by default). Writing 0 to a cause bit clears it and writing 1 leaves it unchanged. Software can never set a cause bit.
- R7: Writing 1 to command bit 1 (disable) makes that bit read 1 and blocks any new command. The command in flight still completes. Once the engine is idle, both the disable bit and the enable bit (bit 0) read 0.
- R8: While command bit 4 (freeze) is set, no new command starts. Clearing it lets pending slots proceed.
- R9: While command bit 2 (channel reset) is set, all four pointers read 0, the sequencer is idle, and a write setting the enable bit is ignored.
- R10: While enabled, a software write to the request in-pointer or the response out-pointer changes only the index field. Writes to the request out-pointer and the response in-pointer have no effect.
- R11: The command register reads back enable in bit 0, disable in bit 1, channel reset in bit 2 and freeze in bit 4. Writing 0 to bit 0 does not stop the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory read request accepted |
| rd_req_addr | output | 32 | Memory read byte address |
| rd_data_valid | input | 1 | Read data beat valid |
| rd_data | input | 32 | Read data beat |
| cmd_valid | output | 1 | Descriptor presented to transport |
| cmd_desc | output | 256 | Latched descriptor, word 0 in low bits |
| cmd_done | input | 1 | Transport completion strobe |
| cmd_status | input | 32 | Completion status with the strobe |
| rsp_wr_valid | output | 1 | Response write valid |
| rsp_wr_ready | input | 1 | Response write accepted |
| rsp_wr_addr | output | 32 | Response entry byte address |
| rsp_wr_data | output | 64 | Response entry |

## Verification
The bench stalls the read and response handshakes on irregular cycles. A design that dropped or reordered a beat would show a descriptor with swapped words, and one that moved its address during a stall would fetch from the wrong slot. The bench drives the indices across 31 to 0. A ring that failed to wrap would write a response outside the 256-byte ring or stall with mismatched indices. The disable is issued while a command is in flight with a second slot queued. Clearing enable too early, or draining the queued slot, shows up in the enable readback and in the out-pointer. The bench also rewrites pointers while the engine is enabled. It shows whether the base bits are kept, and whether a block that let software overwrite its own out-pointers would skip or repeat slots.

// File: rtl/dq_pkg.sv
`timescale 1ns/1ps
package dq_pkg;
    // register offsets
    typedef enum logic [2:0] {
        RA_CMD     = 3'd0,
        RA_REQ_IN  = 3'd1,
        RA_REQ_OUT = 3'd2,
        RA_RSP_IN  = 3'd3,
        RA_RSP_OUT = 3'd4,
        RA_CAUSE   = 3'd5
    } reg_addr_e;

    // command register bit positions
    localparam int CB_EN  = 0;
    localparam int CB_DIS = 1;
    localparam int CB_RST = 2;
    localparam int CB_FRZ = 4;

    // response entry is two words
    localparam int RSP_ENTRY_BYTES = 8;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_REQ  = 3'd1,
        S_BEAT = 3'd2,
        S_CMD  = 3'd3,
        S_RSP  = 3'd4
    } seq_state_e;
endpackage

// File: rtl/dq_ring_ptr.sv
`timescale 1ns/1ps
module dq_ring_ptr #(
    parameter int IDX_LSB = 5,
    parameter int IDX_W   = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        wr,
    input  logic        keep_base,
    input  logic        adv,
    input  logic [31:0] wdata,
    output logic [31:0] q
);
    localparam logic [31:0] IDX_MASK = ((32'd1 << IDX_W) - 32'd1) << IDX_LSB;
    localparam logic [31:0] LOW_MASK = (32'd1 << IDX_LSB) - 32'd1;
    localparam logic [IDX_W-1:0] IDX_TOP = '1;

    typedef struct packed {
        logic [31:0] val;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (clr) begin
            ptr_d.val = '0;
        end else if (adv) begin
            ptr_d.val[IDX_LSB +: IDX_W] = ptr_q.val[IDX_LSB +: IDX_W] + 1'b1;
        end else if (wr) begin
            if (keep_base)
                ptr_d.val = (ptr_q.val & ~IDX_MASK) | (wdata & IDX_MASK);
            else
                ptr_d.val = wdata & ~LOW_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign q = ptr_q.val;

    // R5: index rolls over from the top slot to slot 0
    a_r5_index_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && ptr_q.val[IDX_LSB +: IDX_W] == IDX_TOP)
        |=> (ptr_q.val[IDX_LSB +: IDX_W] == '0));
endmodule

// File: rtl/dq_queue_seq.sv
`timescale 1ns/1ps
module dq_queue_seq
    import dq_pkg::*;
#(
    parameter int NW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            go,
    input  logic [31:0]     slot_addr,
    output logic            busy,
    output logic            rd_req_valid,
    input  logic            rd_req_ready,
    output logic [31:0]     rd_req_addr,
    input  logic            rd_data_valid,
    input  logic [31:0]     rd_data,
    output logic            cmd_valid,
    output logic [NW*32-1:0] cmd_desc,
    input  logic            cmd_done,
    input  logic [31:0]     cmd_status,
    output logic            rsp_valid,
    output logic [31:0]     rsp_status,
    input  logic            rsp_ready,
    output logic            rsp_fire
);
    localparam int DW    = NW * 32;
    localparam int CNT_W = (NW > 1) ? $clog2(NW) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NW - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] wcnt;
        logic [31:0]      slot;
        logic [DW-1:0]    desc;
        logic [31:0]      status;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            S_IDLE: if (go) begin
                s_d.st   = S_REQ;
                s_d.wcnt = '0;
                s_d.slot = slot_addr;
            end
            S_REQ: if (rd_req_ready) s_d.st = S_BEAT;
            S_BEAT: if (rd_data_valid) begin
                s_d.desc[s_q.wcnt*32 +: 32] = rd_data;
                if (s_q.wcnt == LAST) begin
                    s_d.st = S_CMD;
                end else begin
                    s_d.wcnt = s_q.wcnt + 1'b1;
                    s_d.st   = S_REQ;
                end
            end
            S_CMD: if (cmd_done) begin
                s_d.status = cmd_status;
                s_d.st     = S_RSP;
            end
            S_RSP: if (rsp_ready) s_d.st = S_IDLE;
            default: s_d.st = S_IDLE;
        endcase
        if (clr) s_d.st = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy         = (s_q.st != S_IDLE);
    assign rd_req_valid = (s_q.st == S_REQ);
    assign rd_req_addr  = s_q.slot + (32'(s_q.wcnt) << 2);
    assign cmd_valid    = (s_q.st == S_CMD);
    assign cmd_desc     = s_q.desc;
    assign rsp_valid    = (s_q.st == S_RSP);
    assign rsp_status   = s_q.status;
    assign rsp_fire     = rsp_valid && rsp_ready && !clr;

    // R3: descriptor held steady until the transport finishes
    a_r3_desc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done && !clr) |=> (cmd_valid && $stable(cmd_desc)));

    // R3: stalled read request keeps its address
    a_r3_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready && !clr) |=> (rd_req_valid && $stable(rd_req_addr)));

    // R4: response write stays up until accepted
    a_r4_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready && !clr) |=> rsp_valid);
endmodule

// File: rtl/dq_ring_engine.sv
`timescale 1ns/1ps
module dq_ring_engine
    import dq_pkg::*;
#(
    parameter int PORT_ID = 0,
    parameter int NPORTS  = 2,
    parameter int IDX_W   = 5,
    parameter int NW      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             rd_req_valid,
    input  logic             rd_req_ready,
    output logic [31:0]      rd_req_addr,
    input  logic             rd_data_valid,
    input  logic [31:0]      rd_data,
    output logic             cmd_valid,
    output logic [NW*32-1:0] cmd_desc,
    input  logic             cmd_done,
    input  logic [31:0]      cmd_status,
    output logic             rsp_wr_valid,
    input  logic             rsp_wr_ready,
    output logic [31:0]      rsp_wr_addr,
    output logic [63:0]      rsp_wr_data
);
    localparam int REQ_LSB = $clog2(NW * 4);
    localparam int RSP_LSB = $clog2(RSP_ENTRY_BYTES);
    localparam logic [31:0] REQ_IDX_MASK = ((32'd1 << IDX_W) - 32'd1) << REQ_LSB;
    localparam logic [31:0] RSP_IDX_MASK = ((32'd1 << IDX_W) - 32'd1) << RSP_LSB;

    typedef struct packed {
        logic              en;
        logic              dis;
        logic              chrst;
        logic              frz;
        logic [NPORTS-1:0] cause;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [31:0] req_in_q, req_out_q, rsp_in_q, rsp_out_q;
    logic        busy, rsp_fire, go;
    logic [31:0] slot_addr, rsp_status;

    logic cmd_we, cause_we;
    assign cmd_we   = reg_we && (reg_addr == RA_CMD);
    assign cause_we = reg_we && (reg_addr == RA_CAUSE);

    // software-owned pointers: base kept while running
    dq_ring_ptr #(.IDX_LSB(REQ_LSB), .IDX_W(IDX_W)) u_req_in (
        .clk(clk), .rst_n(rst_n), .clr(c_q.chrst),
        .wr(reg_we && reg_addr == RA_REQ_IN), .keep_base(c_q.en),
        .adv(1'b0), .wdata(reg_wdata), .q(req_in_q));
    dq_ring_ptr #(.IDX_LSB(RSP_LSB), .IDX_W(IDX_W)) u_rsp_out (
        .clk(clk), .rst_n(rst_n), .clr(c_q.chrst),
        .wr(reg_we && reg_addr == RA_RSP_OUT), .keep_base(c_q.en),
        .adv(1'b0), .wdata(reg_wdata), .q(rsp_out_q));
    // engine-owned pointers: software writes only while stopped
    dq_ring_ptr #(.IDX_LSB(REQ_LSB), .IDX_W(IDX_W)) u_req_out (
        .clk(clk), .rst_n(rst_n), .clr(c_q.chrst),
        .wr(reg_we && reg_addr == RA_REQ_OUT && !c_q.en), .keep_base(1'b0),
        .adv(rsp_fire), .wdata(reg_wdata), .q(req_out_q));
    dq_ring_ptr #(.IDX_LSB(RSP_LSB), .IDX_W(IDX_W)) u_rsp_in (
        .clk(clk), .rst_n(rst_n), .clr(c_q.chrst),
        .wr(reg_we && reg_addr == RA_RSP_IN && !c_q.en), .keep_base(1'b0),
        .adv(rsp_fire), .wdata(reg_wdata), .q(rsp_in_q));

    assign go = c_q.en && !c_q.dis && !c_q.frz && !c_q.chrst &&
                (req_in_q[REQ_LSB +: IDX_W] != req_out_q[REQ_LSB +: IDX_W]);
    assign slot_addr = (req_in_q & ~REQ_IDX_MASK) | (req_out_q & REQ_IDX_MASK);

    dq_queue_seq #(.NW(NW)) u_seq (
        .clk(clk), .rst_n(rst_n), .clr(c_q.chrst), .go(go),
        .slot_addr(slot_addr), .busy(busy),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_data_valid(rd_data_valid),
        .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_desc(cmd_desc),
        .cmd_done(cmd_done), .cmd_status(cmd_status),
        .rsp_valid(rsp_wr_valid), .rsp_status(rsp_status),
        .rsp_ready(rsp_wr_ready), .rsp_fire(rsp_fire));

    assign rsp_wr_addr = (rsp_out_q & ~RSP_IDX_MASK) | (rsp_in_q & RSP_IDX_MASK);
    assign rsp_wr_data = {rsp_status, {(32-IDX_W){1'b0}}, req_out_q[REQ_LSB +: IDX_W]};

    always_comb begin
        c_d = c_q;
        if (c_q.dis && !busy) begin
            c_d.en  = 1'b0;
            c_d.dis = 1'b0;
        end
        if (cmd_we) begin
            c_d.chrst = reg_wdata[CB_RST];
            c_d.frz   = reg_wdata[CB_FRZ];
            if (reg_wdata[CB_EN])  c_d.en  = 1'b1;
            if (reg_wdata[CB_DIS]) c_d.dis = 1'b1;
        end
        if (c_d.chrst) begin
            c_d.en  = 1'b0;
            c_d.dis = 1'b0;
        end
        if (cause_we) c_d.cause = c_q.cause & reg_wdata[NPORTS-1:0];
        if (rsp_fire) c_d.cause[PORT_ID] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        case (reg_addr)
            RA_CMD:     reg_rdata = {27'd0, c_q.frz, 1'b0, c_q.chrst, c_q.dis, c_q.en};
            RA_REQ_IN:  reg_rdata = req_in_q;
            RA_REQ_OUT: reg_rdata = req_out_q;
            RA_RSP_IN:  reg_rdata = rsp_in_q;
            RA_RSP_OUT: reg_rdata = rsp_out_q;
            RA_CAUSE:   reg_rdata = 32'(c_q.cause);
            default:    reg_rdata = '0;
        endcase
    end

    // R9: enable never coexists with channel reset
    a_r9_no_enable_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.chrst |-> !c_q.en);

    // R7: a pending stop with the sequencer idle drops enable
    a_r7_stop_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.dis && !busy && !(cmd_we && reg_wdata[CB_EN])) |=> !c_q.en);

    // R6: completion raises this port's cause bit
    a_r6_cause_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fire |=> c_q.cause[PORT_ID]);

    // R10: engine-owned out-pointer ignores software while running
    a_r10_owned_ptr_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.en && !c_q.chrst && reg_we && reg_addr == RA_REQ_OUT && !rsp_fire)
        |=> $stable(req_out_q));
endmodule

// File: tb/tb_dq_ring_engine.sv
`timescale 1ns/1ps
module tb_dq_ring_engine;
    import dq_pkg::*;

    localparam logic [31:0] REQB = 32'h0001_0400;
    localparam logic [31:0] RSPB = 32'h0002_0100;

    logic clk = 0, rst_n = 0;
    logic reg_we = 0;
    logic [2:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic rd_req_valid, rd_req_ready = 0, rd_data_valid = 0;
    logic [31:0] rd_req_addr, rd_data = 0;
    logic cmd_valid, cmd_done = 0;
    logic [255:0] cmd_desc;
    logic [31:0] cmd_status = 0;
    logic rsp_wr_valid, rsp_wr_ready = 0;
    logic [31:0] rsp_wr_addr;
    logic [63:0] rsp_wr_data;

    always #2.5 clk = ~clk;

    dq_ring_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_data_valid(rd_data_valid),
        .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_desc(cmd_desc),
        .cmd_done(cmd_done), .cmd_status(cmd_status),
        .rsp_wr_valid(rsp_wr_valid), .rsp_wr_ready(rsp_wr_ready),
        .rsp_wr_addr(rsp_wr_addr), .rsp_wr_data(rsp_wr_data));

    int checks = 0, bad = 0, cyc = 0;
    bit finished = 0;

    // behavioural model state
    logic [31:0]  mem [int];
    logic [255:0] exp_desc [$];
    int           exp_slot [$];
    int           exp_ridx [$];
    int           rsp_idx_model = 0;
    int           rsp_count = 0, cmd_count = 0, seq = 0;
    int           dly = 3, dcnt = 0, dev_n = 0;
    logic [31:0]  last_status = 0;
    bit           cmd_prev = 0, rd_pend = 0;
    logic [31:0]  rd_paddr = 0;

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    // per-clock model comparison and responders, all at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (cmd_valid && !cmd_prev) begin
                cmd_count++;
                if (exp_desc.size() == 0) chk("R3 unexpected command", 1, 0);
                else chk("R3 descriptor words", cmd_desc, exp_desc[0]);
            end
            if (cmd_valid && exp_desc.size() == 0) chk("R3 command with empty model", 1, 0);
        end
        cmd_prev = cmd_valid;
        // transport side
        if (cmd_done) begin
            cmd_done = 0; dcnt = 0;
        end else if (cmd_valid) begin
            if (dcnt >= dly) begin
                dev_n++;
                cmd_status = 32'h5A00_0000 + dev_n;
                last_status = cmd_status;
                cmd_done = 1;
            end else dcnt++;
        end
        // memory read responder
        if (rd_pend) begin
            rd_data_valid = 1;
            rd_data = mem.exists(int'(rd_paddr)) ? mem[int'(rd_paddr)] : 32'h0;
            rd_pend = 0;
        end else rd_data_valid = 0;
        rd_req_ready = (cyc % 3 != 0);
        if (rd_req_valid && rd_req_ready) begin
            rd_pend = 1; rd_paddr = rd_req_addr;
        end
        // response sink
        rsp_wr_ready = (cyc % 4 != 1);
        if (rsp_wr_valid && rsp_wr_ready) begin
            if (exp_slot.size() == 0) chk("R4 unexpected response", 1, 0);
            else begin
                chk("R4 response address", rsp_wr_addr,
                    RSPB | (32'(exp_ridx[0]) << 3));
                chk("R4 response data", rsp_wr_data,
                    {last_status, 27'd0, 5'(exp_slot[0])});
                void'(exp_desc.pop_front());
                void'(exp_slot.pop_front());
                void'(exp_ridx.pop_front());
            end
            rsp_count++;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rdchk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1 chk(tag, reg_rdata, exp);
    endtask

    task automatic submit(input int slot);
        logic [255:0] d;
        for (int w = 0; w < 8; w++) begin
            logic [31:0] word;
            word = {8'(seq), 8'(w), 8'h5C, 8'(slot)};
            mem[int'(REQB + 32'(slot) * 32 + 32'(w) * 4)] = word;
            d[w*32 +: 32] = word;
        end
        seq++;
        exp_desc.push_back(d);
        exp_slot.push_back(slot);
        exp_ridx.push_back(rsp_idx_model);
        rsp_idx_model = (rsp_idx_model + 1) % 32;
    endtask

    task automatic wait_rsp(input int total);
        while (rsp_count < total) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rdchk("R1 cmd reset", RA_CMD, 0);
        rdchk("R1 req_in reset", RA_REQ_IN, 0);
        rdchk("R1 req_out reset", RA_REQ_OUT, 0);
        rdchk("R1 rsp_in reset", RA_RSP_IN, 0);
        rdchk("R1 rsp_out reset", RA_RSP_OUT, 0);
        rdchk("R1 cause reset", RA_CAUSE, 0);
        chk("R1 outputs idle", {cmd_valid, rd_req_valid, rsp_wr_valid}, 0);

        // R2 full writes while stopped, low bits forced to 0
        wr(RA_REQ_OUT, 32'h0000_0123);
        rdchk("R2 req_out masked", RA_REQ_OUT, 32'h0000_0120);
        wr(RA_RSP_IN, 32'h0000_00FF);
        rdchk("R2 rsp_in masked", RA_RSP_IN, 32'h0000_00F8);
        wr(RA_REQ_OUT, 0);
        wr(RA_RSP_IN, 0);
        wr(RA_REQ_IN, REQB);
        wr(RA_RSP_OUT, RSPB);
        rdchk("R2 req_in base", RA_REQ_IN, REQB);
        rdchk("R2 rsp_out base", RA_RSP_OUT, RSPB);

        // R11 enable readback
        wr(RA_CMD, 32'h1);
        rdchk("R11 enable reads back", RA_CMD, 32'h1);

        // R10 engine-owned pointers locked while running
        wr(RA_REQ_OUT, 32'h0000_03E0);
        rdchk("R10 req_out write ignored", RA_REQ_OUT, 0);
        wr(RA_RSP_IN, 32'h0000_00F8);
        rdchk("R10 rsp_in write ignored", RA_RSP_IN, 0);

        // R3 R4 R6 three commands
        submit(0); submit(1); submit(2);
        wr(RA_REQ_IN, REQB | (32'd3 << 5));
        wait_rsp(3);
        rdchk("R4 req_out advanced", RA_REQ_OUT, 32'h60);
        rdchk("R4 rsp_in advanced", RA_RSP_IN, 32'h18);
        rdchk("R6 cause set", RA_CAUSE, 32'h1);

        // R10 base kept on running rewrite
        wr(RA_REQ_IN, 32'hFFFF_F000 | (32'd3 << 5));
        rdchk("R10 req_in base kept", RA_REQ_IN, REQB | 32'h60);
        wr(RA_RSP_OUT, 32'h0000_0018);
        rdchk("R10 rsp_out base kept", RA_RSP_OUT, RSPB | 32'h18);

        // R6 write-one keeps, write-zero clears
        wr(RA_CAUSE, 32'hFFFF_FFFF);
        rdchk("R6 write one keeps", RA_CAUSE, 32'h1);
        wr(RA_CAUSE, 0);
        rdchk("R6 write zero clears", RA_CAUSE, 0);

        // R8 freeze
        wr(RA_CMD, 32'h11);
        rdchk("R11 freeze reads back", RA_CMD, 32'h11);
        submit(3);
        wr(RA_REQ_IN, REQB | (32'd4 << 5));
        repeat (40) @(negedge clk);
        chk("R8 no command while frozen", cmd_count, 3);
        rdchk("R8 req_out held", RA_REQ_OUT, 32'h60);
        wr(RA_CMD, 32'h1);
        wait_rsp(4);
        rdchk("R8 resumes after thaw", RA_REQ_OUT, 32'h80);

        // R7 disable with one command in flight and one queued
        dly = 20;
        submit(4); submit(5);
        wr(RA_REQ_IN, REQB | (32'd6 << 5));
        while (!cmd_valid) @(negedge clk);
        wr(RA_CMD, 32'h2);
        rdchk("R7 enable held while busy", RA_CMD, 32'h3);
        wait_rsp(5);
        repeat (30) @(negedge clk);
        rdchk("R7 enable and disable cleared", RA_CMD, 0);
        rdchk("R7 queued slot not started", RA_REQ_OUT, 32'hA0);
        chk("R7 single completion", rsp_count, 5);
        void'(exp_desc.pop_back());
        void'(exp_slot.pop_back());
        void'(exp_ridx.pop_back());
        dly = 3;

        // R5 wrap across slot 31
        wr(RA_REQ_OUT, 32'd30 << 5);
        wr(RA_RSP_IN, 32'd30 << 3);
        wr(RA_REQ_IN, REQB | (32'd30 << 5));
        rdchk("R2 owned write when stopped", RA_REQ_OUT, 32'h3C0);
        rsp_idx_model = 30;
        wr(RA_CMD, 32'h1);
        submit(30); submit(31); submit(0);
        wr(RA_REQ_IN, REQB | (32'd1 << 5));
        wait_rsp(8);
        rdchk("R5 req_out wrapped", RA_REQ_OUT, 32'h20);
        rdchk("R5 rsp_in wrapped", RA_RSP_IN, 32'h08);

        // R9 channel reset
        wr(RA_CMD, 32'h5);
        rdchk("R9 enable ignored in reset", RA_CMD, 32'h4);
        rdchk("R9 req_in cleared", RA_REQ_IN, 0);
        rdchk("R9 req_out cleared", RA_REQ_OUT, 0);
        rdchk("R9 rsp_in cleared", RA_RSP_IN, 0);
        rdchk("R9 rsp_out cleared", RA_RSP_OUT, 0);
        wr(RA_CMD, 32'h0);
        wr(RA_CMD, 32'h1);
        rdchk("R11 enable after reset release", RA_CMD, 32'h1);
        repeat (10) @(negedge clk);
        chk("R9 no stray command", cmd_count, 8);

        finish_run();
    end
endmodule